// File: doc/BRIEF.md
# Low-Write Composite Counter

This block is an n-bit counter that wraps modulo 2^n. Its state is not kept as plain binary. It uses a mixed code chosen so that each increment rewrites very few stored bits. The lower n-4 bits form a reflected Gray code. The upper 4 bits step through a fixed 16-state sequence in which neighbouring states differ in one or two bits. An increment always advances the Gray field. The upper field moves only on the increment that returns the Gray field to zero, so no increment rewrites more than three stored bits.

The raw stored word is visible on `code_o`. A decoded binary count, `count_o`, is provided so that the count can be compared with ordinary arithmetic. A debug output, `wr_bits_o`, gives the number of stored bits that the most recent clock edge changed. All outputs are registered, and a synchronous active-high reset returns every stored bit to zero.

Top module: `lowwrite_counter`

## Requirements
- R1: When `rst` is high at a clock edge, `code_o`, `count_o` and `wr_bits_o` all become zero on that edge.
- R2: When `inc` is low at a clock edge (and `rst` is low), `code_o` and `count_o` keep their values and `wr_bits_o` becomes 0.
- R3: The low field is `code_o[n-5:0]`, and every increment changes exactly one of its bits. If the field has even parity, bit 0 flips. If it has odd parity, the bit just above its lowest set bit flips.
- R4: When the low field holds only its most significant bit set, an increment clears the low field to all zeros.
- R5: The high field is `code_o[n-1:n-4]`. Written MSB first, it moves through 0000, 0001, 0100, 0101, 1101, 1001, 1100, 1110, 0110, 0111, 1111, 1011, 1000, 1010, 0010, 0011, and then returns to 0000. No step changes more than two of its bits.
- R6: The high field advances by one step only on an increment that wraps the low field to zero. On every other increment it is unchanged.
- R7: `count_o` equals (position of the high field in the R5 sequence) × 2^(n-4) + (binary value of the low Gray field), for the same cycle as `code_o`. Each increment adds 1 modulo 2^n, so 2^n−1 is followed by 0.
- R8: After an increment, `wr_bits_o` equals the number of bits that differ between the previous and the new `code_o`, and it never exceeds 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc | input | 1 | Increment strobe, one step per cycle in which it is high |
| code_o | output | CNT_W | Stored code word: high sequence field above the low Gray field |
| count_o | output | CNT_W | Binary value decoded from the stored code |
| wr_bits_o | output | $clog2(CNT_W+1) | Number of stored bits the last edge changed |

## Verification
On every cycle, the assertions check the following: reset clearing, holding when idle, the one-bit change in the low field, that the high field stays put unless the low field has just reached zero, that the decoded count rises by one per increment, and that the write count matches the actual change in the code and stays at or below three. They cannot show that the low field follows the exact Gray order, or that the high field follows the listed sixteen-state order. The bench shows both by comparing the full code word with a model that is built from the binary count, across several complete wraps of the counter and around a reset in the middle of a run.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

  localparam int HI_W = 4;

  // position in the high sequence -> stored 4-bit pattern
  function automatic logic [HI_W-1:0] hi_code(input logic [HI_W-1:0] idx);
    case (idx)
      4'd0:  hi_code = 4'b0000;
      4'd1:  hi_code = 4'b0001;
      4'd2:  hi_code = 4'b0100;
      4'd3:  hi_code = 4'b0101;
      4'd4:  hi_code = 4'b1101;
      4'd5:  hi_code = 4'b1001;
      4'd6:  hi_code = 4'b1100;
      4'd7:  hi_code = 4'b1110;
      4'd8:  hi_code = 4'b0110;
      4'd9:  hi_code = 4'b0111;
      4'd10: hi_code = 4'b1111;
      4'd11: hi_code = 4'b1011;
      4'd12: hi_code = 4'b1000;
      4'd13: hi_code = 4'b1010;
      4'd14: hi_code = 4'b0010;
      default: hi_code = 4'b0011;
    endcase
  endfunction

  // stored 4-bit pattern -> position in the high sequence
  function automatic logic [HI_W-1:0] hi_index(input logic [HI_W-1:0] code);
    case (code)
      4'b0000: hi_index = 4'd0;
      4'b0001: hi_index = 4'd1;
      4'b0100: hi_index = 4'd2;
      4'b0101: hi_index = 4'd3;
      4'b1101: hi_index = 4'd4;
      4'b1001: hi_index = 4'd5;
      4'b1100: hi_index = 4'd6;
      4'b1110: hi_index = 4'd7;
      4'b0110: hi_index = 4'd8;
      4'b0111: hi_index = 4'd9;
      4'b1111: hi_index = 4'd10;
      4'b1011: hi_index = 4'd11;
      4'b1000: hi_index = 4'd12;
      4'b1010: hi_index = 4'd13;
      4'b0010: hi_index = 4'd14;
      default: hi_index = 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/lwc_gray_step.sv
module lwc_gray_step #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);

  logic found;

  always_comb begin
    nxt_o  = cur_i;
    wrap_o = 1'b0;
    found  = 1'b0;
    if (!(^cur_i)) begin
      nxt_o[0] = ~cur_i[0];
    end else begin
      for (int i = 0; i < W - 1; i++) begin
        if (!found && cur_i[i]) begin
          nxt_o[i+1] = ~cur_i[i+1];
          found      = 1'b1;
        end
      end
      if (!found) begin
        nxt_o  = '0;
        wrap_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lwc_hi_step.sv
module lwc_hi_step
  import lwc_pkg::*;
(
  input  logic [HI_W-1:0] cur_i,
  input  logic            adv_i,
  output logic [HI_W-1:0] nxt_o
);

  logic [HI_W-1:0] pos;

  always_comb begin
    pos   = hi_index(cur_i);
    nxt_o = adv_i ? hi_code(pos + 4'd1) : cur_i;
  end

endmodule

// File: rtl/lwc_decode.sv
module lwc_decode
  import lwc_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int LO_W = CNT_W - HI_W
) (
  input  logic [CNT_W-1:0] code_i,
  output logic [CNT_W-1:0] bin_o
);

  logic [LO_W-1:0] g, b;

  assign g = code_i[LO_W-1:0];

  always_comb begin
    b[LO_W-1] = g[LO_W-1];
    for (int i = LO_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    bin_o = {hi_index(code_i[CNT_W-1 -: HI_W]), b};
  end

endmodule

// File: rtl/lowwrite_counter.sv
module lowwrite_counter
  import lwc_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int LO_W = CNT_W - HI_W,
  localparam int DIST_W = $clog2(CNT_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [CNT_W-1:0]  code_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [DIST_W-1:0] wr_bits_o
);

  logic [CNT_W-1:0] code_q, code_nxt, bin_nxt;
  logic [LO_W-1:0]  lo_adv;
  logic [HI_W-1:0]  hi_adv;
  logic             lo_wrap;

  lwc_gray_step #(.W(LO_W)) u_lo (
    .cur_i  (code_q[LO_W-1:0]),
    .nxt_o  (lo_adv),
    .wrap_o (lo_wrap)
  );

  lwc_hi_step u_hi (
    .cur_i (code_q[CNT_W-1 -: HI_W]),
    .adv_i (lo_wrap),
    .nxt_o (hi_adv)
  );

  assign code_nxt = inc ? {hi_adv, lo_adv} : code_q;

  lwc_decode #(.CNT_W(CNT_W)) u_dec (
    .code_i (code_nxt),
    .bin_o  (bin_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q    <= '0;
      count_o   <= '0;
      wr_bits_o <= '0;
    end else begin
      code_q    <= code_nxt;
      count_o   <= bin_nxt;
      wr_bits_o <= DIST_W'($countones(code_q ^ code_nxt));
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/lwc_checker.sv
module lwc_checker #(
  parameter int CNT_W = 8,
  localparam int LO_W = CNT_W - 4,
  localparam int DIST_W = $clog2(CNT_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              inc,
  input logic [CNT_W-1:0]  code_o,
  input logic [CNT_W-1:0]  count_o,
  input logic [DIST_W-1:0] wr_bits_o
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (code_o == '0 && count_o == '0 && wr_bits_o == '0));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !inc |=> ($stable(code_o) && $stable(count_o) && wr_bits_o == '0));

  a_r3_low_one_flip: assert property (@(posedge clk) disable iff (rst)
    inc |=> ($countones(code_o[LO_W-1:0] ^ $past(code_o[LO_W-1:0])) == 1));

  a_r6_high_on_wrap: assert property (@(posedge clk) disable iff (rst)
    inc |=> ($stable(code_o[CNT_W-1 -: 4]) || code_o[LO_W-1:0] == '0));

  a_r5_high_two_max: assert property (@(posedge clk) disable iff (rst)
    inc |=> ($countones(code_o[CNT_W-1 -: 4] ^ $past(code_o[CNT_W-1 -: 4])) <= 2));

  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    inc |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

  a_r8_write_count: assert property (@(posedge clk) disable iff (rst)
    inc |=> (wr_bits_o == DIST_W'($countones(code_o ^ $past(code_o)))));

  a_r8_write_limit: assert property (@(posedge clk) disable iff (rst)
    wr_bits_o <= 3);

endmodule

bind lowwrite_counter lwc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inc       (inc),
  .code_o    (code_o),
  .count_o   (count_o),
  .wr_bits_o (wr_bits_o)
);

// File: tb/sim_lowwrite_counter.sv
`timescale 1ns/1ps
module sim_lowwrite_counter;

  localparam int CNT_W  = 8;
  localparam int LO_W   = CNT_W - 4;
  localparam int DIST_W = $clog2(CNT_W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inc = 1'b0;
  logic [CNT_W-1:0]  code_o, count_o;
  logic [DIST_W-1:0] wr_bits_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int unsigned model;        // binary count
  logic [CNT_W-1:0] prev_code;

  always #2.5 clk = ~clk;

  lowwrite_counter #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .inc(inc),
    .code_o(code_o), .count_o(count_o), .wr_bits_o(wr_bits_o)
  );

  function automatic logic [3:0] seq(input int unsigned p);
    logic [3:0] t [16] = '{4'b0000, 4'b0001, 4'b0100, 4'b0101, 4'b1101, 4'b1001,
                           4'b1100, 4'b1110, 4'b0110, 4'b0111, 4'b1111, 4'b1011,
                           4'b1000, 4'b1010, 4'b0010, 4'b0011};
    return t[p % 16];
  endfunction

  function automatic logic [CNT_W-1:0] exp_code(input int unsigned m);
    logic [LO_W-1:0] b;
    b = LO_W'(m);
    return {seq(m >> LO_W), b ^ (b >> 1)};
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // one clock with a given strobe, then compare with the model
  task automatic step(input bit s);
    logic [CNT_W-1:0] e;
    int unsigned lo_prev;
    @(negedge clk);
    inc = s;
    prev_code = code_o;
    lo_prev = model % (1 << LO_W);
    @(posedge clk);
    #1;
    if (s) model = (model + 1) % (1 << CNT_W);
    e = exp_code(model);
    if (s) begin
      if (lo_prev == (1 << LO_W) - 1)
        check("R4 low wrap", int'(code_o[LO_W-1:0]), 0);
      else
        check("R3 low gray", int'(code_o[LO_W-1:0]), int'(e[LO_W-1:0]));
      if (lo_prev == (1 << LO_W) - 1)
        check("R5 high seq", int'(code_o[CNT_W-1 -: 4]), int'(e[CNT_W-1 -: 4]));
      else
        check("R6 high held", int'(code_o[CNT_W-1 -: 4]), int'(prev_code[CNT_W-1 -: 4]));
      check("R7 count", int'(count_o), int'(model));
      check("R8 writes", int'(wr_bits_o), $countones(prev_code ^ e));
      if (wr_bits_o > 3) check("R8 limit", int'(wr_bits_o), 3);
    end else begin
      check("R2 hold code", int'(code_o), int'(prev_code));
      check("R2 hold count", int'(count_o), int'(model));
      check("R2 writes", int'(wr_bits_o), 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    inc = 1'b1;
    @(posedge clk);
    #1;
    model = 0;
    check("R1 code", int'(code_o), 0);
    check("R1 count", int'(count_o), 0);
    check("R1 writes", int'(wr_bits_o), 0);
    @(negedge clk);
    rst = 1'b0;
    inc = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model = 0;
    repeat (2) @(posedge clk);
    do_reset();
    // idle cycles right after reset
    repeat (3) step(1'b0);
    // full sweep past the top value: 2^n - 1 -> 0
    for (int i = 0; i < (1 << CNT_W) + 5; i++) step(1'b1);
    check("R7 wrapped", int'(count_o), 5);
    // random strobe pattern
    for (int i = 0; i < 700; i++) step(($urandom % 4) != 0);
    // reset in the middle of counting, then count again
    do_reset();
    for (int i = 0; i < 40; i++) step(1'b1);
    repeat (2) step(1'b0);
    for (int i = 0; i < 600; i++) step(($urandom % 3) != 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule